// File: doc/BRIEF.md
# Stepped-Level Resistive Cell Write Sequencer

This block controls a single write to a resistive memory cell. It produces a train of write pulses and gives each pulse a voltage level code for an external analog driver. A SET write begins at the programmed start level and lowers the code by the programmed step after every pulse. A RESET write begins at the start level and raises the code by the step after every pulse. The code saturates at zero and at its all-ones value. An external current detector raises a feedback flag when the cell has switched. The sequencer resynchronises that flag and ends the write within the pulse that is running. No read-verify phase is ever issued.

Software or a higher-level controller programs the start level, the step size, the number of steps and two pulse widths in clock cycles, one for SET and one for RESET. It then raises start for one cycle. The block reports the outcome with a one-cycle done pulse. If the last step ends without feedback, fail is raised together with done. Between two pulses the strobe stays low for a fixed short gap of GAP_CYCLES cycles, and during that gap the level code already shows the next value.

Top module: `rram_step_writer`

## Requirements
- R1: With op_reset_i = 0 (SET), pulse k (counting from 0) carries level code start_lvl_i minus k times step_size_i, floored at 0, so the level never rises from one pulse to the next.
- R2: With op_reset_i = 1 (RESET), pulse k carries level code start_lvl_i plus k times step_size_i, capped at the all-ones code, so the level never falls from one pulse to the next.
- R3: Once the level code has saturated at 0 (SET) or at all ones (RESET), every remaining pulse keeps that saturated value.
- R4: Each pulse holds wr_en_o high for set_width_i cycles in SET and reset_width_i cycles in RESET; a width of 0 acts as 1.
- R5: With no feedback, wr_en_o stays low for exactly GAP_CYCLES cycles between consecutive pulses (default 2), and no other phase comes between them.
- R6: When fb_i rises during a pulse, wr_en_o is low and done_o is high at the third rising clock edge after the rise, fail_o stays low, and no further pulse follows.
- R7: fb_i raised while the block is idle has no effect: done_o, busy_o and wr_en_o stay low.
- R8: step_cnt_i sets the number of pulses, with 0 acting as 1; if the last pulse ends without feedback, done_o and fail_o are high together for one cycle.
- R9: busy_o goes high in the cycle after start is accepted, stays high through every pulse and gap, and is low in the cycle that reports done_o.
- R10: A start_i pulse while busy_o is high is ignored, and the write in progress runs on unchanged.
- R11: After reset, and whenever no write is in progress, wr_en_o, busy_o, done_o, fail_o and lvl_o are all zero.
- R12: done_o and fail_o are never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a write when the block is idle |
| op_reset_i | input | 1 | 0 selects SET (descending steps), 1 selects RESET (ascending steps) |
| fb_i | input | 1 | Asynchronous switched-cell flag from the current detector |
| start_lvl_i | input | LVL_W | Level code of the first pulse |
| step_size_i | input | LVL_W | Level change applied between pulses |
| step_cnt_i | input | CNT_W | Maximum number of pulses |
| set_width_i | input | WID_W | SET pulse width in cycles |
| reset_width_i | input | WID_W | RESET pulse width in cycles |
| wr_en_o | output | 1 | Write strobe to the driver |
| lvl_o | output | LVL_W | Voltage level code to the driver |
| busy_o | output | 1 | Write in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | One-cycle pulse with done_o when no switch was seen |

## Verification
The bound checker watches, on every cycle, that done and fail are single-cycle pulses, that fail never appears without done, that the strobe only runs while busy and busy is low at completion, that the level code is zero outside a write, that each SET pulse is no higher than the one before and each RESET pulse no lower, that a successful completion always follows a pulse, and that a start during a write causes no reload. Only the directed scenarios show the exact level values with saturation, the pulse widths for each operation and the zero-width case, the exact gap length, the pulse count for a given step count, the three-edge feedback latency, and that feedback in idle does nothing.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PULSE,
        ST_GAP,
        ST_DONE,
        ST_FAIL
    } rsw_state_e;

endpackage

// File: rtl/rsw_fb_sync.sv
module rsw_fb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsw_level_next.sv
module rsw_level_next #(
    parameter int LVL_W = 4
) (
    input  logic             up_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0] step_i,
    output logic [LVL_W-1:0] lvl_o
);
    logic [LVL_W:0] sum;

    always_comb begin
        sum = {1'b0, lvl_i} + {1'b0, step_i};
        if (up_i) begin
            lvl_o = sum[LVL_W] ? {LVL_W{1'b1}} : sum[LVL_W-1:0];
        end else begin
            lvl_o = (lvl_i >= step_i) ? (lvl_i - step_i) : '0;
        end
    end
endmodule

// File: rtl/rsw_pulse_len.sv
module rsw_pulse_len #(
    parameter int WID_W = 8
) (
    input  logic [WID_W-1:0] width_i,
    output logic [WID_W-1:0] reload_o
);
    always_comb begin
        reload_o = (width_i == '0) ? '0 : (width_i - WID_W'(1));
    end
endmodule

// File: rtl/rram_step_writer.sv
module rram_step_writer #(
    parameter int LVL_W       = 4,
    parameter int CNT_W       = 4,
    parameter int WID_W       = 8,
    parameter int GAP_CYCLES  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_reset_i,
    input  logic             fb_i,
    input  logic [LVL_W-1:0] start_lvl_i,
    input  logic [LVL_W-1:0] step_size_i,
    input  logic [CNT_W-1:0] step_cnt_i,
    input  logic [WID_W-1:0] set_width_i,
    input  logic [WID_W-1:0] reset_width_i,
    output logic             wr_en_o,
    output logic [LVL_W-1:0] lvl_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o
);
    import rsw_pkg::*;

    localparam int GAP_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYCLES - 1);

    typedef struct packed {
        rsw_state_e       state;
        logic             op;
        logic [LVL_W-1:0] first_lvl;
        logic [LVL_W-1:0] step;
        logic [LVL_W-1:0] lvl;
        logic [CNT_W-1:0] left_cnt;
        logic [WID_W-1:0] width;
        logic [WID_W-1:0] timer;
        logic [GAP_W-1:0] gap;
        logic             fb_hit;
    } ctl_t;

    ctl_t r_d, r_q;

    logic             fb_s;
    logic [LVL_W-1:0] lvl_step;
    logic [WID_W-1:0] reload;

    rsw_fb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (fb_i),
        .sync_o  (fb_s)
    );

    rsw_level_next #(.LVL_W(LVL_W)) u_lvl (
        .up_i   (r_q.op),
        .lvl_i  (r_q.lvl),
        .step_i (r_q.step),
        .lvl_o  (lvl_step)
    );

    rsw_pulse_len #(.WID_W(WID_W)) u_len (
        .width_i  (r_q.width),
        .reload_o (reload)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state     = ST_LOAD;
                    r_d.op        = op_reset_i;
                    r_d.first_lvl = start_lvl_i;
                    r_d.step      = step_size_i;
                    r_d.left_cnt  = (step_cnt_i == '0) ? '0 : (step_cnt_i - CNT_W'(1));
                    r_d.width     = op_reset_i ? reset_width_i : set_width_i;
                    r_d.fb_hit    = 1'b0;
                end
            end
            ST_LOAD: begin
                r_d.lvl   = r_q.first_lvl;
                r_d.timer = reload;
                r_d.state = ST_PULSE;
            end
            ST_PULSE: begin
                if (fb_s) begin
                    r_d.fb_hit = 1'b1;
                    r_d.state  = ST_DONE;
                end else if (r_q.timer == '0) begin
                    if (r_q.left_cnt == '0) begin
                        r_d.state = ST_FAIL;
                    end else begin
                        r_d.lvl      = lvl_step;
                        r_d.left_cnt = r_q.left_cnt - CNT_W'(1);
                        r_d.gap      = GAP_LOAD;
                        r_d.state    = ST_GAP;
                    end
                end else begin
                    r_d.timer = r_q.timer - WID_W'(1);
                end
            end
            ST_GAP: begin
                if (r_q.gap == '0) begin
                    r_d.timer = reload;
                    r_d.state = ST_PULSE;
                end else begin
                    r_d.gap = r_q.gap - GAP_W'(1);
                end
            end
            ST_DONE, ST_FAIL: begin
                r_d.lvl    = '0;
                r_d.fb_hit = 1'b0;
                r_d.state  = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_en_o = (r_q.state == ST_PULSE);
    assign lvl_o   = ((r_q.state == ST_PULSE) || (r_q.state == ST_GAP)) ? r_q.lvl : '0;
    assign busy_o  = (r_q.state == ST_LOAD) || (r_q.state == ST_PULSE) || (r_q.state == ST_GAP);
    assign done_o  = (r_q.state == ST_DONE) || (r_q.state == ST_FAIL);
    assign fail_o  = (r_q.state == ST_FAIL);
endmodule

// File: rtl/rsw_checker.sv
module rsw_checker #(
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             op_reset_i,
    input logic             wr_en_o,
    input logic [LVL_W-1:0] lvl_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             fail_o
);
    logic             op_q;
    logic [LVL_W-1:0] last_lvl_q;
    logic             last_vld_q;
    logic             accept;

    assign accept = start_i && !busy_o && !done_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= 1'b0;
            last_lvl_q <= '0;
            last_vld_q <= 1'b0;
        end else begin
            if (accept) op_q <= op_reset_i;
            if (!busy_o) begin
                last_vld_q <= 1'b0;
            end else if (wr_en_o) begin
                last_lvl_q <= lvl_o;
                last_vld_q <= 1'b1;
            end
        end
    end

    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> done_o);

    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r9_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o);

    a_r11_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (lvl_o == '0));

    a_r1_set_descends: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && last_vld_q && !op_q) |-> (lvl_o <= last_lvl_q));

    a_r2_reset_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && last_vld_q && op_q) |-> (lvl_o >= last_lvl_q));

    a_r6_success_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fail_o) |-> $past(wr_en_o));

    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && wr_en_o && start_i) |=> (busy_o || done_o));
endmodule

bind rram_step_writer rsw_checker #(.LVL_W(LVL_W)) u_rsw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_reset_i (op_reset_i),
    .wr_en_o    (wr_en_o),
    .lvl_o      (lvl_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
);

// File: tb/rram_step_writer_tb_top.sv
`timescale 1ns/1ps
module rram_step_writer_tb_top;
    localparam int LVL_W = 4;
    localparam int CNT_W = 4;
    localparam int WID_W = 8;
    localparam int GAP   = 2;
    localparam int LMAX  = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             op_reset_i = 1'b0;
    logic             fb_i = 1'b0;
    logic [LVL_W-1:0] start_lvl_i = '0;
    logic [LVL_W-1:0] step_size_i = '0;
    logic [CNT_W-1:0] step_cnt_i = '0;
    logic [WID_W-1:0] set_width_i = '0;
    logic [WID_W-1:0] reset_width_i = '0;
    logic             wr_en_o;
    logic [LVL_W-1:0] lvl_o;
    logic             busy_o;
    logic             done_o;
    logic             fail_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rram_step_writer #(.LVL_W(LVL_W), .CNT_W(CNT_W), .WID_W(WID_W), .GAP_CYCLES(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_reset_i(op_reset_i), .fb_i(fb_i),
        .start_lvl_i(start_lvl_i), .step_size_i(step_size_i), .step_cnt_i(step_cnt_i),
        .set_width_i(set_width_i), .reset_width_i(reset_width_i),
        .wr_en_o(wr_en_o), .lvl_o(lvl_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
    );

    // Monitor state, sampled at the falling edge
    int  npulse, ndone, nfail, nbusybad, nlvlchg;
    int  lvls [0:15];
    int  lens [0:15];
    int  gaps [0:15];
    int  cur_len, gap_run;
    bit  prev_wr;

    task automatic clear_mon();
        npulse = 0; ndone = 0; nfail = 0; nbusybad = 0; nlvlchg = 0;
        cur_len = 0; gap_run = 0; prev_wr = 1'b0;
        for (int i = 0; i < 16; i++) begin lvls[i] = -1; lens[i] = -1; gaps[i] = -1; end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en_o && !prev_wr) begin
                if (npulse > 0 && npulse < 16) gaps[npulse-1] = gap_run;
                if (npulse < 16) lvls[npulse] = int'(lvl_o);
                npulse++;
                cur_len = 1;
            end else if (wr_en_o) begin
                cur_len++;
                if (npulse > 0 && npulse <= 16 && lvls[npulse-1] != int'(lvl_o)) nlvlchg++;
            end else if (prev_wr) begin
                if (npulse > 0 && npulse <= 16) lens[npulse-1] = cur_len;
                gap_run = 1;
            end else begin
                gap_run++;
            end
            if (wr_en_o && !busy_o) nbusybad++;
            if (done_o && busy_o) nbusybad++;
            if (done_o) ndone++;
            if (fail_o) nfail++;
            prev_wr = wr_en_o;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_lvl(input bit up, input int first, input int step, input int k);
        int v = first;
        for (int i = 0; i < k; i++) begin
            if (up) v = (v + step > LMAX) ? LMAX : v + step;
            else    v = (v < step) ? 0 : v - step;
        end
        return v;
    endfunction

    task automatic launch(input bit up, input int first, input int step, input int cnt,
                          input int sw, input int rw);
        @(negedge clk);
        op_reset_i    = up;
        start_lvl_i   = LVL_W'(first);
        step_size_i   = LVL_W'(step);
        step_cnt_i    = CNT_W'(cnt);
        set_width_i   = WID_W'(sw);
        reset_width_i = WID_W'(rw);
        clear_mon();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check(busy_o == 1'b1, "R9 busy after start", int'(busy_o), 1);
    endtask

    task automatic wait_done();
        while (ndone == 0) begin @(negedge clk); #1; end
        @(negedge clk); #1;
    endtask

    task automatic check_train(input bit up, input int first, input int step, input int n,
                               input int w, input string tag);
        check(npulse == n, {tag, " pulse count"}, npulse, n);
        for (int k = 0; k < n && k < 16; k++) begin
            check(lvls[k] == model_lvl(up, first, step, k), {tag, " level"}, lvls[k],
                  model_lvl(up, first, step, k));
            check(lens[k] == w, "R4 pulse width", lens[k], w);
            if (k < n - 1) check(gaps[k] == GAP, "R5 gap length", gaps[k], GAP);
        end
        check(nlvlchg == 0, "R4 level stable in pulse", nlvlchg, 0);
        check(nbusybad == 0, "R9 busy framing", nbusybad, 0);
        check(ndone == 1, "R12 single done", ndone, 1);
    endtask

    task automatic t_reset_state();
        #1;
        check(wr_en_o == 0 && busy_o == 0 && done_o == 0 && fail_o == 0, "R11 reset outputs",
              int'({wr_en_o, busy_o, done_o, fail_o}), 0);
        check(lvl_o == '0, "R11 reset level", int'(lvl_o), 0);
    endtask

    task automatic t_set_no_fb();
        launch(1'b0, 12, 3, 4, 8, 125);
        wait_done();
        check_train(1'b0, 12, 3, 4, 8, "R1");
        check(nfail == 1, "R8 fail on exhaustion", nfail, 1);
        check(lvl_o == '0 && busy_o == 0, "R11 idle after write", int'(lvl_o), 0);
    endtask

    task automatic t_reset_no_fb();
        launch(1'b1, 2, 4, 5, 8, 20);
        wait_done();
        check_train(1'b1, 2, 4, 5, 20, "R2");
        check(lvls[4] == LMAX, "R3 saturate high", lvls[4], LMAX);
        check(nfail == 1, "R8 fail on exhaustion", nfail, 1);
    endtask

    task automatic t_set_saturate();
        launch(1'b0, 5, 3, 4, 6, 30);
        wait_done();
        check_train(1'b0, 5, 3, 4, 6, "R3");
        check(lvls[2] == 0 && lvls[3] == 0, "R3 saturate low", lvls[3], 0);
    endtask

    task automatic t_zero_len();
        launch(1'b0, 9, 1, 0, 0, 30);
        wait_done();
        check(npulse == 1, "R8 zero count acts as one", npulse, 1);
        check(lens[0] == 1, "R4 zero width acts as one", lens[0], 1);
        check(nfail == 1, "R8 fail with done", nfail, 1);
    endtask

    task automatic fb_run(input bit up, input int idx, input int w, input string tag);
        launch(up, 8, 2, 6, w, w);
        while (npulse < idx + 1) begin @(negedge clk); #1; end
        @(negedge clk); #1;
        fb_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(wr_en_o == 1'b0, {tag, " strobe cut"}, int'(wr_en_o), 0);
        check(done_o == 1'b1 && fail_o == 1'b0, {tag, " done without fail"},
              int'({done_o, fail_o}), 2);
        fb_i = 1'b0;
        repeat (6) @(negedge clk);
        #1;
        check(npulse == idx + 1, {tag, " no later pulse"}, npulse, idx + 1);
        check(nfail == 0 && ndone == 1, "R12 single done", ndone, 1);
    endtask

    task automatic t_fb_idle();
        int bad = 0;
        @(negedge clk);
        clear_mon();
        fb_i = 1'b1;
        repeat (5) begin
            @(negedge clk); #1;
            if (done_o || busy_o || wr_en_o) bad++;
        end
        fb_i = 1'b0;
        repeat (4) @(negedge clk);
        check(bad == 0 && ndone == 0, "R7 idle feedback ignored", bad, 0);
    endtask

    task automatic t_start_busy();
        launch(1'b0, 10, 2, 3, 8, 125);
        while (npulse < 2) begin @(negedge clk); #1; end
        op_reset_i  = 1'b1;
        start_lvl_i = 4'd1;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check(npulse == 3, "R10 start ignored count", npulse, 3);
        check(lvls[2] == 6, "R10 start ignored level", lvls[2], 6);
        check(lens[2] == 8, "R10 start ignored width", lens[2], 8);
        check(ndone == 1, "R10 single completion", ndone, 1);
    endtask

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_set_no_fb();
        t_reset_no_fb();
        t_set_saturate();
        t_zero_len();
        fb_run(1'b0, 1, 8, "R6 set");
        fb_run(1'b1, 0, 40, "R6 reset");
        t_fb_idle();
        t_start_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule